// File: doc/BRIEF.md
# Remote Terminal Host Register Interface

This block sits between a host processor and the protocol engine of a bus remote terminal. The host writes an 8-bit control register and reads a 16-bit system register through a strobe-based port: a chip-select, a control-space strobe, a read/not-write line and address bit 0. Four of the control bits are the status-word flags that the terminal sends back on the bus: service request, subsystem flag, busy and terminal flag. One further bit enables the external terminal address lines.

The flags go onto the bus through a small message-phase state machine. Its inputs are the protocol engine's command-strobe and STATUS levels, which the block turns into edge events. A write that sets a flag reaches the outgoing status word at once, up to and including the clock in which STATUS rises. A write that clears a flag waits for the next command-strobe rising edge, and only counts there if it was registered at least one clock earlier. The block also keeps a valid-message latch. The latch is set when STATUS rises and is cleared by a system register read.

States: `ST_IDLE` (between messages), `ST_CMD` (a command has been strobed and no status yet), `ST_RESP` (STATUS high, flags frozen). Transitions: `ST_IDLE`→`ST_CMD` on a command rise; `ST_IDLE`→`ST_RESP` and `ST_CMD`→`ST_RESP` on a STATUS rise, which wins over a command rise in the same clock; `ST_CMD`→`ST_CMD` on a further command rise, which recaptures the flags; `ST_RESP`→`ST_IDLE` on a STATUS fall. Reset enters `ST_IDLE`.

Top module: `hcr_host_regs`

## Requirements
- R1: A control write happens on a clock edge where host_ctrl=1, host_sel=1, host_rd=0 and host_a0=0. The control register then holds host_wdata, and its value is visible in sys_rdata[12:5] on the next read.
- R2: A write strobe with host_a0=1, host_sel=0 or host_ctrl=0 changes nothing: ext_addr_en, sw_flags and the control register keep their values.
- R3: A system read happens on an edge where host_ctrl=1, host_sel=1, host_rd=1 and host_a0=0. It loads sys_rdata with {3'b0, control[7:0], sw_flags[3:0], msg_valid} as they were before that edge. A read strobe with host_a0=1 or host_sel=0 leaves sys_rdata and msg_valid unchanged.
- R4: Outside ST_RESP, a write that sets any of control bits 3:0 (bit 0 service request, 1 subsystem flag, 2 busy, 3 terminal flag) shows on sw_flags one clock later. This includes a write in the same clock as the STATUS rise.
- R5: While in ST_RESP, sw_flags does not change. Set bits written during ST_RESP appear on sw_flags one clock after the state returns to ST_IDLE.
- R6: sw_flags loses bits only on a command-strobe rise. There it takes the control register value registered before that edge, ORed with any set bits written in the same clock. A clear written in the same clock as the rise waits for the following command.
- R7: A STATUS rise sets msg_valid on the next clock.
- R8: A system read clears msg_valid. If the read and a STATUS rise fall in the same clock, msg_valid ends up 1 and the read returns the old value.
- R9: After reset, sys_rdata, sw_flags, msg_valid and ext_addr_en are all 0 and the state is ST_IDLE.
- R10: ext_addr_en follows control bit 4 from the clock after each accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ctrl | input | 1 | Host control-space strobe |
| host_sel | input | 1 | Host chip select |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_a0 | input | 1 | Host address bit 0; registers decode at 0 |
| host_wdata | input | 8 | Control write data |
| pe_status | input | 1 | STATUS level from the protocol engine |
| pe_cmd_strobe | input | 1 | Command strobe level from the protocol engine |
| sys_rdata | output | 16 | Registered system register read data |
| sw_flags | output | 4 | Flags placed in the outgoing status word |
| msg_valid | output | 1 | Valid-message latch |
| ext_addr_en | output | 1 | External terminal address lines enable |

## Verification
The bench sweeps every pair of old and new flag values across command strobes. A design that let a clear take effect early, or ignored sets between commands, would return a wrong flag word. The bench also goes after each race: a clear in the same clock as the command rise, which a careless design applies at once; a set in the same clock as the STATUS rise, which a design sampling only the stored register would drop; a write during STATUS high, which must not leak into the word being sent; and a read colliding with a STATUS rise, where giving the read priority would lose a message. Strobes with a wrong address bit, select or control line must leave every output untouched.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_RESP = 2'd2
    } hcr_state_e;

endpackage

// File: rtl/hcr_strobe_dec.sv
module hcr_strobe_dec (
    input  logic host_ctrl,
    input  logic host_sel,
    input  logic host_rd,
    input  logic host_a0,
    output logic wr_fire,
    output logic rd_fire
);
    logic base_hit;

    always_comb begin
        base_hit = host_ctrl && host_sel && !host_a0;
        wr_fire  = base_hit && !host_rd;
        rd_fire  = base_hit && host_rd;
    end
endmodule

// File: rtl/hcr_edge_det.sv
module hcr_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= lvl[g];
        end
        always_comb begin
            rise[g] = lvl[g] && !lvl_q[g];
            fall[g] = !lvl[g] && lvl_q[g];
        end
    end
endmodule

// File: rtl/hcr_flag_seq.sv
module hcr_flag_seq
    import hcr_pkg::*;
#(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rise,
    input  logic              stat_rise,
    input  logic              stat_fall,
    input  logic              wr_fire,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic [FLAG_W-1:0] ctl_flags,
    output hcr_state_e        state,
    output logic [FLAG_W-1:0] sw_flags
);
    hcr_state_e        state_nx;
    logic [FLAG_W-1:0] set_now;
    logic [FLAG_W-1:0] sw_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (stat_rise)     state_nx = ST_RESP;
                else if (cmd_rise) state_nx = ST_CMD;
            end
            ST_CMD: begin
                if (stat_rise) state_nx = ST_RESP;
            end
            ST_RESP: begin
                if (stat_fall) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // flag word: sets flow through, clears only at a command rise
    always_comb begin
        set_now = wr_fire ? wr_flags : '0;
        sw_nx   = sw_flags;
        unique case (state)
            ST_RESP: sw_nx = sw_flags;
            ST_IDLE, ST_CMD: begin
                if (cmd_rise) sw_nx = ctl_flags | set_now;
                else          sw_nx = sw_flags | ctl_flags | set_now;
            end
            default: sw_nx = sw_flags;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) sw_flags <= '0;
        else        sw_flags <= sw_nx;
    end
endmodule

// File: rtl/hcr_msg_latch.sv
module hcr_msg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic valid
);
    always_ff @(posedge clk) begin
        if (!rst_n)       valid <= 1'b0;
        else if (set_evt) valid <= 1'b1;
        else if (clr_evt) valid <= 1'b0;
    end
endmodule

// File: rtl/hcr_host_regs.sv
module hcr_host_regs
    import hcr_pkg::*;
#(
    parameter int CTRL_W     = 8,
    parameter int FLAG_W     = 4,
    parameter int SYS_W      = 16,
    parameter int EXT_EN_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ctrl,
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_a0,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              pe_status,
    input  logic              pe_cmd_strobe,
    output logic [SYS_W-1:0]  sys_rdata,
    output logic [FLAG_W-1:0] sw_flags,
    output logic              msg_valid,
    output logic              ext_addr_en
);
    localparam int CTL_LO = FLAG_W + 1;
    localparam int CTL_HI = FLAG_W + CTRL_W;
    localparam int EV_CMD = 0;
    localparam int EV_STAT = 1;

    logic              wr_fire;
    logic              rd_fire;
    logic [1:0]        ev_lvl;
    logic [1:0]        ev_rise;
    logic [1:0]        ev_fall;
    logic              cmd_rise;
    logic              stat_rise;
    logic              stat_fall;
    logic [CTRL_W-1:0] ctl_q;
    logic [SYS_W-1:0]  sys_word;
    hcr_state_e        state;

    hcr_strobe_dec u_dec (
        .host_ctrl (host_ctrl),
        .host_sel  (host_sel),
        .host_rd   (host_rd),
        .host_a0   (host_a0),
        .wr_fire   (wr_fire),
        .rd_fire   (rd_fire)
    );

    assign ev_lvl = {pe_status, pe_cmd_strobe};

    hcr_edge_det #(.N(2)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ev_lvl),
        .rise  (ev_rise),
        .fall  (ev_fall)
    );

    assign cmd_rise  = ev_rise[EV_CMD];
    assign stat_rise = ev_rise[EV_STAT];
    assign stat_fall = ev_fall[EV_STAT];

    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_q <= '0;
        else if (wr_fire) ctl_q <= host_wdata;
    end

    assign ext_addr_en = ctl_q[EXT_EN_BIT];

    hcr_flag_seq #(.FLAG_W(FLAG_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_rise  (cmd_rise),
        .stat_rise (stat_rise),
        .stat_fall (stat_fall),
        .wr_fire   (wr_fire),
        .wr_flags  (host_wdata[FLAG_W-1:0]),
        .ctl_flags (ctl_q[FLAG_W-1:0]),
        .state     (state),
        .sw_flags  (sw_flags)
    );

    hcr_msg_latch u_vml (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (stat_rise),
        .clr_evt (rd_fire),
        .valid   (msg_valid)
    );

    always_comb begin
        sys_word                = '0;
        sys_word[0]             = msg_valid;
        sys_word[FLAG_W:1]      = sw_flags;
        sys_word[CTL_HI:CTL_LO] = ctl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       sys_rdata <= '0;
        else if (rd_fire) sys_rdata <= sys_word;
    end
endmodule

// File: rtl/hcr_host_regs_chk.sv
module hcr_host_regs_chk
    import hcr_pkg::*;
#(
    parameter int CTRL_W     = 8,
    parameter int FLAG_W     = 4,
    parameter int SYS_W      = 16,
    parameter int EXT_EN_BIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_fire,
    input logic              rd_fire,
    input logic [CTRL_W-1:0] wdata,
    input logic              stat_rise,
    input logic              cmd_rise,
    input hcr_state_e        state,
    input logic [FLAG_W-1:0] sw_flags,
    input logic              msg_valid,
    input logic [SYS_W-1:0]  sys_rdata,
    input logic              ext_addr_en
);
    // R4: a set written outside the response phase is on the flags next clock
    a_r4_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && state != ST_RESP) |=>
        ((sw_flags & $past(wdata[FLAG_W-1:0])) == $past(wdata[FLAG_W-1:0])));

    // R5: flags frozen while STATUS is high
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP) |=> $stable(sw_flags));

    // R6: no flag drops without a command rise
    a_r6_no_early_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rise |=> (($past(sw_flags) & ~sw_flags) == '0));

    // R7: STATUS rise sets the latch
    a_r7_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rise |=> msg_valid);

    // R8: a read without a coinciding STATUS rise clears the latch
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !stat_rise) |=> !msg_valid);

    // R3: read returns the latch value from before the read
    a_r3_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> (sys_rdata[0] == $past(msg_valid)));

    // R10: address enable follows the written bit
    a_r10_ext_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (ext_addr_en == $past(wdata[EXT_EN_BIT])));
endmodule

bind hcr_host_regs hcr_host_regs_chk #(
    .CTRL_W     (CTRL_W),
    .FLAG_W     (FLAG_W),
    .SYS_W      (SYS_W),
    .EXT_EN_BIT (EXT_EN_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_fire     (wr_fire),
    .rd_fire     (rd_fire),
    .wdata       (host_wdata),
    .stat_rise   (stat_rise),
    .cmd_rise    (cmd_rise),
    .state       (state),
    .sw_flags    (sw_flags),
    .msg_valid   (msg_valid),
    .sys_rdata   (sys_rdata),
    .ext_addr_en (ext_addr_en)
);

// File: tb/test_hcr_host_regs.sv
module test_hcr_host_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_ctrl, host_sel, host_rd, host_a0;
    logic [7:0]  host_wdata;
    logic        pe_status, pe_cmd_strobe;
    logic [15:0] sys_rdata;
    logic [3:0]  sw_flags;
    logic        msg_valid, ext_addr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    hcr_host_regs i_hcr_host_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_ctrl     (host_ctrl),
        .host_sel      (host_sel),
        .host_rd       (host_rd),
        .host_a0       (host_a0),
        .host_wdata    (host_wdata),
        .pe_status     (pe_status),
        .pe_cmd_strobe (pe_cmd_strobe),
        .sys_rdata     (sys_rdata),
        .sw_flags      (sw_flags),
        .msg_valid     (msg_valid),
        .ext_addr_en   (ext_addr_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        host_ctrl = 0; host_sel = 0; host_rd = 0; host_a0 = 0; host_wdata = '0;
    endtask

    task automatic strobe(input logic c, input logic s, input logic r, input logic a, input logic [7:0] d);
        host_ctrl = c; host_sel = s; host_rd = r; host_a0 = a; host_wdata = d;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic wr(input logic [7:0] d);
        strobe(1, 1, 0, 0, d);
    endtask

    task automatic rd();
        strobe(1, 1, 1, 0, 8'h00);
    endtask

    task automatic cmd_pulse();
        pe_cmd_strobe = 1;
        @(negedge clk);
        pe_cmd_strobe = 0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] sysw(input logic [7:0] c, input logic [3:0] f, input logic v);
        return {3'b000, c, f, v};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        rst_n = 0; pe_status = 0; pe_cmd_strobe = 0;
        bus_idle();
        repeat (3) @(negedge clk);
        // R9 reset values
        chk("R9 sys_rdata", sys_rdata, 0);
        chk("R9 sw_flags", sw_flags, 0);
        chk("R9 msg_valid", msg_valid, 0);
        chk("R9 ext_addr_en", ext_addr_en, 0);
        rst_n = 1;
        @(negedge clk);

        // R10 / R1 address enable bit 4
        wr(8'h10);
        chk("R10 enable set", ext_addr_en, 1);
        chk("R1 flags untouched by bit4", sw_flags, 0);
        wr(8'h00);
        chk("R10 enable clear", ext_addr_en, 0);

        // R2 rejected write strobes
        strobe(1, 1, 0, 1, 8'hFF);
        chk("R2 a0=1 ext", ext_addr_en, 0);
        chk("R2 a0=1 flags", sw_flags, 0);
        strobe(1, 0, 0, 0, 8'hFF);
        chk("R2 sel=0 ext", ext_addr_en, 0);
        chk("R2 sel=0 flags", sw_flags, 0);
        strobe(0, 1, 0, 0, 8'hFF);
        chk("R2 ctrl=0 ext", ext_addr_en, 0);
        chk("R2 ctrl=0 flags", sw_flags, 0);
        rd();
        chk("R2 R1 control unchanged", sys_rdata, sysw(8'h00, 4'h0, 1'b0));

        // R1 R3 R4 R6 exhaustive old/new flag sweep
        for (int p = 0; p < 16; p++) begin
            for (int n = 0; n < 16; n++) begin
                wr({4'h0, p[3:0]});
                cmd_pulse();
                chk("R6 capture at command", sw_flags, p[3:0]);
                wr({4'h0, n[3:0]});
                chk("R4 set between commands", sw_flags, p[3:0] | n[3:0]);
                rd();
                chk("R3 R1 read word", sys_rdata, sysw({4'h0, n[3:0]}, p[3:0] | n[3:0], 1'b0));
                cmd_pulse();
                chk("R6 clear at next command", sw_flags, n[3:0]);
            end
        end

        // R6 clear in the same clock as the command rise waits
        wr(8'h0F);
        cmd_pulse();
        chk("R6 preload", sw_flags, 4'hF);
        pe_cmd_strobe = 1;
        strobe(1, 1, 0, 0, 8'h00);
        pe_cmd_strobe = 0;
        @(negedge clk);
        chk("R6 same-clock clear deferred", sw_flags, 4'hF);
        cmd_pulse();
        chk("R6 deferred clear applied", sw_flags, 4'h0);

        // R4 R7 set in the same clock as STATUS rise
        pe_status = 1;
        wr(8'h04);
        chk("R4 set at status rise", sw_flags, 4'h4);
        chk("R7 latch set", msg_valid, 1);

        // R5 frozen while STATUS high
        wr(8'h02);
        chk("R5 frozen in response", sw_flags, 4'h4);
        rd();
        chk("R3 read in response", sys_rdata, sysw(8'h02, 4'h4, 1'b1));
        chk("R8 read clears latch", msg_valid, 0);
        pe_status = 0;
        @(negedge clk);
        chk("R5 held on status fall", sw_flags, 4'h4);
        @(negedge clk);
        chk("R5 pending set after fall", sw_flags, 4'h6);
        cmd_pulse();
        chk("R6 clear after response", sw_flags, 4'h2);

        // R8 read colliding with STATUS rise
        pe_status = 1;
        rd();
        chk("R8 collision read old", sys_rdata[0], 0);
        chk("R8 collision set wins", msg_valid, 1);

        // R3 rejected read strobes
        held = sys_rdata;
        strobe(1, 1, 1, 1, 8'h00);
        chk("R3 a0=1 rdata held", sys_rdata, held);
        chk("R3 a0=1 latch kept", msg_valid, 1);
        strobe(1, 0, 1, 0, 8'h00);
        chk("R3 sel=0 rdata held", sys_rdata, held);
        chk("R3 sel=0 latch kept", msg_valid, 1);
        rd();
        chk("R3 read after collision", sys_rdata, sysw(8'h02, 4'h2, 1'b1));
        chk("R8 cleared", msg_valid, 0);
        pe_status = 0;
        @(negedge clk);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule